// File: doc/BRIEF.md
# General Register File with Paired Writeback

This block is the integer register file of a five-stage in-order pipeline. It holds thirty-two 32-bit registers. The decode stage reads two operands through two combinational read ports. The writeback stage updates the file through a single write port. That port can also place a second value into the register just above the addressed one, so a wide result such as a 64-bit product lands in a register pair from one writeback. Register 0 is a constant zero.

The file behaves as if it writes in the first half of the cycle and reads in the second half. A read of a register that is being written in the same cycle therefore returns the incoming value rather than the stored one. This lets an instruction in decode see the result that is retiring in the same cycle, without any forwarding network. The pass-through covers both the low and the high word of a paired write, on both read ports. A synchronous reset clears the whole file.

Top module: `gpr_bank`

## Requirements
- R1: A cycle with `rst` high clears every register to zero at the clock edge and performs no write. After reset, every register reads zero until it is written.
- R2: Reading address 0 returns zero on either port at all times. A write or paired low word aimed at register 0 is discarded, and it is not passed through to a read of register 0.
- R3: With `wr_en` high, `wr_lo` is stored at the clock edge in the register named by `wr_addr`. Later reads of that register return it until it is written again.
- R4: With `wr_en` and `pair_en` both high, the same edge also stores `wr_hi` in register `wr_addr`+1. When `wr_addr` is 0, only register 1 changes.
- R5: A paired write with `wr_addr` = 31 stores `wr_lo` in register 31 and drops the high word. Register 0 stays zero and no other register changes.
- R6: When `wr_en` is low, no register changes, whatever the values of `pair_en`, `wr_addr`, `wr_lo` and `wr_hi`.
- R7: During a cycle with `wr_en` high, a read of register `wr_addr` (nonzero) on either port returns `wr_lo` in that same cycle.
- R8: During a cycle with `wr_en` and `pair_en` high and `wr_addr` below 31, a read of register `wr_addr`+1 on either port returns `wr_hi` in that same cycle.
- R9: The two read ports are independent. Each port returns the value of its own address in the same cycle, including when the two addresses differ or are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all register updates happen on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the file |
| wr_en | input | 1 | Writeback enable for the low word |
| pair_en | input | 1 | Also write the high word into the next register (used only with wr_en) |
| wr_addr | input | 5 | Writeback register index |
| wr_lo | input | 32 | Low word, written to register wr_addr |
| wr_hi | input | 32 | High word, written to register wr_addr+1 |
| rd_addr_a | input | 5 | Read port A register index |
| rd_data_a | output | 32 | Read port A data |
| rd_addr_b | input | 5 | Read port B register index |
| rd_data_b | output | 32 | Read port B data |

## Verification
Reads are combinational, so each read result belongs to the cycle in which its address is presented. A write takes effect at the next rising edge, and its pass-through value is due in the same cycle as the write itself. The driver applies one cycle of inputs just after a falling edge and queues the two read values due in that cycle, computed from a shadow copy of the file plus the pass-through rules. The monitor takes each queued pair 3 ns later, before the rising edge at which the stored contents move on. Stored state is then checked from the following cycle onward.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  // Index of the partner register in a paired write.
  function automatic int unsigned pair_index(input int unsigned base);
    return base + 1;
  endfunction

  // A pair partner exists only when it still falls inside the file.
  function automatic logic pair_in_range(input int unsigned base, input int unsigned depth);
    return (base + 1) < depth;
  endfunction

  // Write-first selection: a same-cycle write wins over the stored word.
  function automatic logic [31:0] pick_first32(input logic lo_sel, input logic hi_sel,
                                               input logic [31:0] lo_val,
                                               input logic [31:0] hi_val,
                                               input logic [31:0] held);
    if (lo_sel) return lo_val;
    if (hi_sel) return hi_val;
    return held;
  endfunction

endpackage

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode #(
  parameter int NUM_REGS = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              rst,
  input  logic              wr_en,
  input  logic              pair_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [NUM_REGS-1:0] lo_hit,
  output logic [NUM_REGS-1:0] hi_hit,
  output logic              hi_dropped
);
  import gpr_pkg::*;

  logic lo_fire;
  logic hi_fire;
  logic hi_room;

  assign lo_fire    = wr_en & ~rst;
  assign hi_room    = pair_in_range(int'(wr_addr), NUM_REGS);
  assign hi_fire    = lo_fire & pair_en & hi_room;
  assign hi_dropped = lo_fire & pair_en & ~hi_room;

  genvar i;
  generate
    for (i = 0; i < NUM_REGS; i++) begin : g_dec
      if (i == 0) begin : g_zero
        assign lo_hit[i] = 1'b0;
        assign hi_hit[i] = 1'b0;
      end else begin : g_live
        assign lo_hit[i] = lo_fire & (wr_addr == ADDR_W'(i));
        assign hi_hit[i] = hi_fire & (ADDR_W'(pair_index(int'(wr_addr))) == ADDR_W'(i));
      end
    end
  endgenerate

endmodule

// File: rtl/gpr_store.sv
module gpr_store #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_REGS-1:0]            lo_hit,
  input  logic [NUM_REGS-1:0]            hi_hit,
  input  logic [DATA_W-1:0]              wr_lo,
  input  logic [DATA_W-1:0]              wr_hi,
  output logic [NUM_REGS-1:0][DATA_W-1:0] cells
);

  genvar i;
  generate
    for (i = 0; i < NUM_REGS; i++) begin : g_cell
      if (i == 0) begin : g_const
        assign cells[i] = '0;
      end else begin : g_flop
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
          if (rst) begin
            q <= '0;
          end else if (lo_hit[i]) begin
            q <= wr_lo;
          end else if (hi_hit[i]) begin
            q <= wr_hi;
          end
        end
        assign cells[i] = q;
      end
    end
  endgenerate

endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic [ADDR_W-1:0]               rd_addr,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] cells,
  input  logic [NUM_REGS-1:0]             lo_hit,
  input  logic [NUM_REGS-1:0]             hi_hit,
  input  logic [DATA_W-1:0]               wr_lo,
  input  logic [DATA_W-1:0]               wr_hi,
  output logic [DATA_W-1:0]               rd_data,
  output logic                            pass_hit
);

  logic              sel_lo;
  logic              sel_hi;
  logic [DATA_W-1:0] held;

  assign sel_lo   = lo_hit[rd_addr];
  assign sel_hi   = hi_hit[rd_addr];
  assign held     = cells[rd_addr];
  assign pass_hit = sel_lo | sel_hi;

  always_comb begin
    if (sel_lo) begin
      rd_data = wr_lo;
    end else if (sel_hi) begin
      rd_data = wr_hi;
    end else begin
      rd_data = held;
    end
  end

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              pair_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_lo,
  input  logic [DATA_W-1:0] wr_hi,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b
);

  localparam int NPORT = 2;

  logic [NUM_REGS-1:0]             lo_hit;
  logic [NUM_REGS-1:0]             hi_hit;
  logic                            hi_dropped;
  logic [NUM_REGS-1:0][DATA_W-1:0] cells;
  logic [NPORT-1:0][ADDR_W-1:0]    port_addr;
  logic [NPORT-1:0][DATA_W-1:0]    port_data;
  logic [NPORT-1:0]                pass_hit;

  gpr_wr_decode #(.NUM_REGS(NUM_REGS)) u_dec (
    .rst       (rst),
    .wr_en     (wr_en),
    .pair_en   (pair_en),
    .wr_addr   (wr_addr),
    .lo_hit    (lo_hit),
    .hi_hit    (hi_hit),
    .hi_dropped(hi_dropped)
  );

  gpr_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst   (rst),
    .lo_hit(lo_hit),
    .hi_hit(hi_hit),
    .wr_lo (wr_lo),
    .wr_hi (wr_hi),
    .cells (cells)
  );

  assign port_addr[0] = rd_addr_a;
  assign port_addr[1] = rd_addr_b;

  genvar p;
  generate
    for (p = 0; p < NPORT; p++) begin : g_port
      gpr_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd (
        .rd_addr (port_addr[p]),
        .cells   (cells),
        .lo_hit  (lo_hit),
        .hi_hit  (hi_hit),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .rd_data (port_data[p]),
        .pass_hit(pass_hit[p])
      );
    end
  endgenerate

  assign rd_data_a = port_data[0];
  assign rd_data_b = port_data[1];

endmodule

// File: rtl/gpr_bank_chk.sv
module gpr_bank_chk #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                pair_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [DATA_W-1:0]   wr_lo,
  input logic [DATA_W-1:0]   wr_hi,
  input logic [ADDR_W-1:0]   rd_addr_a,
  input logic [DATA_W-1:0]   rd_data_a,
  input logic [ADDR_W-1:0]   rd_addr_b,
  input logic [DATA_W-1:0]   rd_data_b,
  input logic [NUM_REGS-1:0] lo_hit,
  input logic [NUM_REGS-1:0] hi_hit,
  input logic                hi_dropped,
  input logic [1:0]          pass_hit
);

  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(NUM_REGS - 1);

  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !wr_en) |-> (rd_data_a == '0 && rd_data_b == '0));

  // R2
  zero_port_a_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == '0) |-> (rd_data_a == '0 && !pass_hit[0]));

  // R2
  zero_port_b_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_b == '0) |-> (rd_data_b == '0 && !pass_hit[1]));

  // R3
  lo_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lo_hit));

  // R4
  hi_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hi_hit));

  // R5
  top_pair_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && pair_en && wr_addr == TOP) |-> (hi_dropped && hi_hit == '0));

  // R6
  idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en) |-> (lo_hit == '0 && hi_hit == '0 && pass_hit == '0));

  // R7
  lo_pass_a_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != '0 && rd_addr_a == wr_addr) |-> (rd_data_a == wr_lo));

  // R7
  lo_pass_b_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != '0 && rd_addr_b == wr_addr) |-> (rd_data_b == wr_lo));

  // R8
  hi_pass_a_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && pair_en && wr_addr != TOP && rd_addr_a == ADDR_W'(wr_addr + ADDR_W'(1))
     && rd_addr_a != wr_addr) |-> (rd_data_a == wr_hi));

  // R8
  hi_pass_b_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && pair_en && wr_addr != TOP && rd_addr_b == ADDR_W'(wr_addr + ADDR_W'(1))
     && rd_addr_b != wr_addr) |-> (rd_data_b == wr_hi));

  // R9
  same_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b));

endmodule

bind gpr_bank gpr_bank_chk #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .pair_en   (pair_en),
  .wr_addr   (wr_addr),
  .wr_lo     (wr_lo),
  .wr_hi     (wr_hi),
  .rd_addr_a (rd_addr_a),
  .rd_data_a (rd_data_a),
  .rd_addr_b (rd_addr_b),
  .rd_data_b (rd_data_b),
  .lo_hit    (lo_hit),
  .hi_hit    (hi_hit),
  .hi_dropped(hi_dropped),
  .pass_hit  (pass_hit)
);

// File: tb/tb_gpr_bank.sv
module tb_gpr_bank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        pair_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_lo = '0;
  logic [31:0] wr_hi = '0;
  logic [4:0]  rd_addr_a = '0;
  logic [4:0]  rd_addr_b = '0;
  logic [31:0] rd_data_a;
  logic [31:0] rd_data_b;

  always #4 clk = ~clk;

  gpr_bank dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .pair_en(pair_en), .wr_addr(wr_addr),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] model [32];
  logic [31:0] q_a [$];
  logic [31:0] q_b [$];
  string       q_tag [$];

  function automatic logic [31:0] expect_rd(input logic [4:0] ra, input logic we,
                                            input logic pe, input logic [4:0] wa,
                                            input logic [31:0] lo, input logic [31:0] hi);
    if (ra == 5'd0) return 32'd0;
    if (we && ra == wa) return lo;
    if (we && pe && wa != 5'd31 && ra == wa + 5'd1) return hi;
    return model[ra];
  endfunction

  task automatic step(input logic r, input logic we, input logic pe, input logic [4:0] wa,
                      input logic [31:0] lo, input logic [31:0] hi,
                      input logic [4:0] ra, input logic [4:0] rb, input string tag);
    @(negedge clk);
    rst = r; wr_en = we; pair_en = pe; wr_addr = wa; wr_lo = lo; wr_hi = hi;
    rd_addr_a = ra; rd_addr_b = rb;
    if (!r) begin
      q_a.push_back(expect_rd(ra, we, pe, wa, lo, hi));
      q_b.push_back(expect_rd(rb, we, pe, wa, lo, hi));
      q_tag.push_back(tag);
    end
    if (r) begin
      for (int k = 0; k < 32; k++) model[k] = 32'd0;
    end else if (we) begin
      if (wa != 5'd0) model[wa] = lo;
      if (pe && wa != 5'd31) model[wa + 5'd1] = hi;
    end
  endtask

  // Monitor: takes the values due in the current cycle, before the next rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (q_a.size() > 0) begin
        logic [31:0] ea, eb;
        string t;
        ea = q_a.pop_front(); eb = q_b.pop_front(); t = q_tag.pop_front();
        checks++;
        if (rd_data_a !== ea) begin
          fails++;
          $display("FAIL %s port A: actual %h expected %h", t, rd_data_a, ea);
        end
        checks++;
        if (rd_data_b !== eb) begin
          fails++;
          $display("FAIL %s port B: actual %h expected %h", t, rd_data_b, eb);
        end
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    for (int k = 0; k < 32; k++) model[k] = 32'd0;
    step(1, 0, 0, 0, 0, 0, 0, 0, "reset");
    step(1, 0, 0, 0, 0, 0, 0, 0, "reset");
    // R1: everything reads zero after reset
    for (int k = 0; k < 32; k += 2) step(0, 0, 0, 0, 0, 0, 5'(k), 5'(k + 1), "R1 post-reset");

    // R7 then R3: pass-through of low word, then stored value
    step(0, 1, 0, 5, 32'hA5A5_0001, 32'hFFFF_FFFF, 5, 5, "R7 low pass-through");
    step(0, 0, 0, 0, 0, 0, 5, 6, "R3 stored low word");

    // R8 and R4: pair at 10
    step(0, 1, 1, 10, 32'h1111_0010, 32'h2222_0011, 10, 11, "R8 pair pass-through");
    step(0, 0, 0, 0, 0, 0, 11, 10, "R4 stored pair");
    step(0, 1, 1, 20, 32'h3333_0020, 32'h4444_0021, 21, 20, "R8 high word on port A");
    step(0, 0, 0, 0, 0, 0, 20, 21, "R4 stored pair 20/21");

    // R5: pair at the top register
    step(0, 1, 1, 31, 32'h5555_0031, 32'hDEAD_BEEF, 31, 0, "R5 top pair pass-through");
    step(0, 0, 0, 0, 0, 0, 31, 0, "R5 high word dropped");
    step(0, 0, 0, 0, 0, 0, 30, 1, "R5 neighbours untouched");

    // R2/R4: pair at 0 writes only register 1
    step(0, 1, 1, 0, 32'h7777_0000, 32'h8888_0001, 0, 1, "R2 pair at zero");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R4 pair at zero stores r1");
    step(0, 1, 0, 0, 32'hFFFF_FFFF, 0, 0, 0, "R2 write to zero ignored");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R2 zero after write");

    // R6: pair_en without wr_en
    step(0, 0, 1, 10, 32'h9999_9999, 32'hAAAA_AAAA, 10, 11, "R6 no write without enable");
    step(0, 0, 0, 0, 0, 0, 10, 11, "R6 registers kept");

    // R9: independent ports
    step(0, 0, 0, 0, 0, 0, 5, 21, "R9 different addresses");
    step(0, 1, 0, 7, 32'h0BAD_F00D, 0, 7, 20, "R9 one port passes, one stored");

    // Overwrite: a pair writes over an earlier single write
    step(0, 1, 1, 4, 32'hC0DE_0004, 32'hC0DE_0005, 5, 4, "R3 overwrite by pair");
    step(0, 0, 0, 0, 0, 0, 4, 5, "R3 overwrite stored");

    // Random traffic
    for (int n = 0; n < 400; n++) begin
      logic we, pe;
      logic [4:0] wa, ra, rb;
      we = 1'($urandom_range(0, 1)); pe = 1'($urandom_range(0, 1));
      wa = 5'($urandom_range(0, 31));
      ra = (n % 3 == 0) ? wa : 5'($urandom_range(0, 31));
      rb = (n % 4 == 0) ? wa + 5'd1 : 5'($urandom_range(0, 31));
      step(0, we, pe, wa, $urandom, $urandom, ra, rb, "R3 R4 R7 R8 R9 random");
    end

    // R1: reset again with a write pending; write must not land
    step(1, 1, 1, 12, 32'h1234_5678, 32'h8765_4321, 0, 0, "reset");
    for (int k = 0; k < 32; k += 2) step(0, 0, 0, 0, 0, 0, 5'(k), 5'(k + 1), "R1 reset clears file");

    @(negedge clk);
    wr_en = 1'b0; pair_en = 1'b0;
    @(negedge clk);
    #4;
    done = 1'b1;
    finish_run();
  end

endmodule